// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave

This block is the slave end of a two-wire serial bus in front of a 256-byte storage array. It oversamples the clock and data lines with the system clock, finds start and stop conditions, and checks the 7-bit device address. That address is a fixed `1010` type code followed by three select bits taken from a pin. The slave acknowledges each byte by pulling the data line low through an open-drain enable. It never drives the line high.

Writes carry a one-byte word address and then data bytes. The data bytes land in a four-entry page latch. Within the page, only the two low address bits advance, so a fifth byte wraps onto the first slot. The stop that ends a write starts an internal write cycle, which is timed in clock cycles. The latch is copied into the array only when that cycle ends. While the cycle runs, the busy flag is high and the slave answers nothing, so a master can poll for completion by sending the address until it is acknowledged.

Three kinds of read are supported. A current-address read returns the byte at the internal pointer. A random read first sends a write header with the word address, then a repeated start and a read header. A sequential read continues as long as the master acknowledges each byte. The block has no parallel data stream: every byte moves over the serial pins, and the pace is set only by the master's clock, so there is no back-pressure path.

Top module: `ee2w_slave`

## Requirements
- R1: After reset the open-drain enable `sda_pull_o` is low, `busy_o` is low, and every array byte reads as 0x00.
- R2: An address byte whose upper seven bits equal `1010` followed by `dev_sel_i` is acknowledged, meaning the line is pulled low on the ninth clock. Any other address is not acknowledged, and the slave stays off the bus until the next start.
- R3: In a write, the slave acknowledges the word address byte and every data byte. A single data byte written to an address is read back unchanged once the write cycle has ended.
- R4: After each received data byte, only the two low bits of the address pointer step by one and the upper six bits stay fixed. A fifth or later byte wraps to the page start and replaces the earlier byte in that slot, and bytes outside the page are untouched.
- R5: A stop that ends a write with at least one data byte raises `busy_o` for `WRITE_CYCLES` clock cycles. The buffered bytes appear in the array when `busy_o` falls.
- R6: While `busy_o` is high, no address byte is acknowledged and `sda_pull_o` stays low.
- R7: A write interrupted by a repeated start before its stop commits nothing, and it does not raise `busy_o`.
- R8: A random read returns the byte at the word address given in the preceding write header.
- R9: A current-address read returns the byte one above the last byte read.
- R10: In a read, the master's low acknowledge on the ninth clock makes the slave send the next byte. The pointer steps through all 8 bits and wraps from 0xFF to 0x00.
- R11: A high level on the master's ninth clock ends the read. The slave then releases the line and sends nothing more until a new start.
- R12: `sda_pull_o` changes only while SCL is low, so the slave never forms a start or stop condition itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line from the master |
| sda_i | input | 1 | Serial data line as seen on the wire |
| dev_sel_i | input | 3 | Device select bits compared with the address byte |
| sda_pull_o | output | 1 | Open-drain enable; high pulls the data line low |
| busy_o | output | 1 | High while the internal write cycle runs |

## Verification
The main function is exercised with four kinds of traffic:
- **Single-byte writes** read back through random and current-address reads. These separate the word-address load from the pointer step that follows a read.
- **A six-byte page write starting mid-page**, read back sequentially across both page edges. This tells a two-bit wrap apart from a full-pointer increment, and it shows that neighbouring bytes are not touched.
- **A sequential read across 0xFF.** This checks the full 8-bit wrap that reads use, which differs from the page wrap that writes use.
- **Lockout and abort cases.** These are polling during the write cycle, a write abandoned with a repeated start, wrong select bits or type code, and extra clocks after a master NACK. Each one should leave the bus undriven or the array unchanged.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;
  localparam int BYTE_W = 8;
  localparam int WADDR_W = 8;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_WDATA,
    ST_RDATA
  } bus_state_t;
endpackage

// File: rtl/ee2w_bus_sense.sv
module ee2w_bus_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_sync[SYNC_STAGES-1];
      sda_q    <= sda_sync[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_sync[SYNC_STAGES-1];
  assign sda_o      = sda_sync[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/ee2w_page_latch.sv
module ee2w_page_latch #(
  parameter int DATA_W       = 8,
  parameter int PAGE_W       = 2,
  parameter int BASE_W       = 6,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clear_i,
  input  logic                              wr_en_i,
  input  logic [PAGE_W-1:0]                 wr_idx_i,
  input  logic [BASE_W-1:0]                 wr_base_i,
  input  logic [DATA_W-1:0]                 wr_data_i,
  input  logic                              arm_i,
  output logic                              busy_o,
  output logic                              commit_o,
  output logic [BASE_W-1:0]                 commit_base_o,
  output logic [(1<<PAGE_W)-1:0]            commit_mask_o,
  output logic [(1<<PAGE_W)-1:0][DATA_W-1:0] commit_data_o
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int CNT_W  = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WRITE_CYCLES - 1);

  logic [PAGE_N-1:0] mask_q;
  logic [BASE_W-1:0] base_q;
  logic [CNT_W-1:0]  tmr_q;
  logic              busy_q;

  for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
    logic [DATA_W-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= '0;
      else if (wr_en_i && wr_idx_i == PAGE_W'(g)) ent_q <= wr_data_i;
    end
    assign commit_data_o[g] = ent_q;
  end

  assign commit_o = busy_q && (tmr_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      base_q <= '0;
    end else if (commit_o || (clear_i && !busy_q)) begin
      mask_q <= '0;
    end else if (wr_en_i) begin
      mask_q[wr_idx_i] <= 1'b1;
      base_q           <= wr_base_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tmr_q  <= '0;
    end else if (!busy_q) begin
      if (arm_i && |mask_q) begin
        busy_q <= 1'b1;
        tmr_q  <= '0;
      end
    end else if (commit_o) begin
      busy_q <= 1'b0;
    end else begin
      tmr_q <= tmr_q + 1'b1;
    end
  end

  assign busy_o        = busy_q;
  assign commit_base_o = base_q;
  assign commit_mask_o = mask_q;

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !commit_o) |=> busy_q);
  // R5
  commit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> (!busy_q && mask_q == '0));
  // R5
  commit_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (mask_q != '0));
endmodule

// File: rtl/ee2w_array.sv
module ee2w_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [ADDR_W-1:0]                   rd_addr_i,
  output logic [DATA_W-1:0]                   rd_data_o,
  input  logic                                commit_i,
  input  logic [ADDR_W-PAGE_W-1:0]            commit_base_i,
  input  logic [(1<<PAGE_W)-1:0]              commit_mask_i,
  input  logic [(1<<PAGE_W)-1:0][DATA_W-1:0]  commit_data_i
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (commit_i) begin
      for (int i = 0; i < PAGE_N; i++)
        if (commit_mask_i[i]) mem_q[{commit_base_i, PAGE_W'(i)}] <= commit_data_i[i];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
  import ee2w_pkg::*;
#(
  parameter int PAGE_W       = 2,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel_i,
  output logic       sda_pull_o,
  output logic       busy_o
);
  localparam int BASE_W = WADDR_W - PAGE_W;
  localparam int PAGE_N = 1 << PAGE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  ee2w_bus_sense #(.SYNC_STAGES(2)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  bus_state_t          state_q;
  logic [3:0]          cnt_q;
  logic [BYTE_W-1:0]   shr_q, tx_q, rd_data;
  logic [WADDR_W-1:0]  addr_q;
  logic                ackd_q, drv_q, rw_q;
  logic                rx_state, byte_done, addr_ok, byte_ok;
  logic                lat_clear, lat_wr, commit;
  logic [BASE_W-1:0]   commit_base;
  logic [PAGE_N-1:0]   commit_mask;
  logic [PAGE_N-1:0][BYTE_W-1:0] commit_data;

  assign rx_state  = (state_q == ST_DEV) || (state_q == ST_WORD) || (state_q == ST_WDATA);
  assign byte_done = rx_state && scl_fall && (cnt_q == 4'd8) && !ackd_q;
  assign addr_ok   = (shr_q[7:1] == {DEV_TYPE, dev_sel_i}) && !busy_o;
  assign byte_ok   = (state_q != ST_DEV) || addr_ok;
  assign lat_wr    = byte_done && (state_q == ST_WDATA);
  assign lat_clear = (start_det && !busy_o) || (byte_done && state_q == ST_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shr_q   <= '0;
      tx_q    <= '1;
      addr_q  <= '0;
      ackd_q  <= 1'b0;
      drv_q   <= 1'b0;
      rw_q    <= 1'b0;
    end else if (start_det) begin
      state_q <= ST_DEV;
      cnt_q   <= '0;
      ackd_q  <= 1'b0;
      drv_q   <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      ackd_q  <= 1'b0;
      drv_q   <= 1'b0;
    end else if (rx_state) begin
      if (scl_rise && cnt_q < 4'd8) begin
        shr_q <= {shr_q[6:0], sda_s};
        cnt_q <= cnt_q + 4'd1;
      end else if (scl_fall && cnt_q == 4'd8) begin
        if (ackd_q) begin
          ackd_q <= 1'b0;
          cnt_q  <= '0;
          unique case (state_q)
            ST_DEV: if (rw_q) begin
              state_q <= ST_RDATA;
              tx_q    <= rd_data;
              drv_q   <= 1'b1;
              addr_q  <= addr_q + 8'd1;
            end else begin
              state_q <= ST_WORD;
            end
            ST_WORD: state_q <= ST_WDATA;
            default: state_q <= ST_WDATA;
          endcase
        end else if (byte_ok) begin
          ackd_q <= 1'b1;
          if (state_q == ST_DEV)  rw_q <= shr_q[0];
          if (state_q == ST_WORD) addr_q <= shr_q;
          if (state_q == ST_WDATA)
            addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
        end else begin
          state_q <= ST_IDLE;
        end
      end
    end else if (state_q == ST_RDATA) begin
      if (scl_rise) begin
        if (cnt_q < 4'd8) cnt_q <= cnt_q + 4'd1;
        else if (cnt_q == 4'd8) begin
          if (!sda_s) cnt_q <= 4'd9;
          else state_q <= ST_IDLE;
        end
      end else if (scl_fall) begin
        if (cnt_q >= 4'd1 && cnt_q <= 4'd7) begin
          tx_q <= {tx_q[6:0], 1'b1};
        end else if (cnt_q == 4'd8) begin
          drv_q <= 1'b0;
        end else if (cnt_q == 4'd9) begin
          tx_q   <= rd_data;
          drv_q  <= 1'b1;
          addr_q <= addr_q + 8'd1;
          cnt_q  <= '0;
        end
      end
    end
  end

  assign sda_pull_o = ackd_q || (drv_q && !tx_q[7]);

  ee2w_page_latch #(
    .DATA_W(BYTE_W), .PAGE_W(PAGE_W), .BASE_W(BASE_W), .WRITE_CYCLES(WRITE_CYCLES)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .clear_i(lat_clear), .wr_en_i(lat_wr),
    .wr_idx_i(addr_q[PAGE_W-1:0]), .wr_base_i(addr_q[WADDR_W-1:PAGE_W]),
    .wr_data_i(shr_q), .arm_i(stop_det), .busy_o(busy_o), .commit_o(commit),
    .commit_base_o(commit_base), .commit_mask_o(commit_mask), .commit_data_o(commit_data)
  );

  ee2w_array #(.ADDR_W(WADDR_W), .DATA_W(BYTE_W), .PAGE_W(PAGE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_addr_i(addr_q), .rd_data_o(rd_data),
    .commit_i(commit), .commit_base_i(commit_base), .commit_mask_i(commit_mask),
    .commit_data_i(commit_data)
  );

  // R6
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_pull_o);
  // R12
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !scl_s);
  // R4
  page_base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_wr |=> (addr_q[WADDR_W-1:PAGE_W] == $past(addr_q[WADDR_W-1:PAGE_W])));
  // R10
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RDATA && scl_fall && cnt_q == 4'd9) |=> (addr_q == $past(addr_q) + 8'd1));
endmodule

// File: tb/sim_ee2w_slave.sv
module sim_ee2w_slave;
  localparam int CLK_P = 10;
  localparam int Q     = 8;
  localparam int WC    = 1000;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, SEL, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, SEL, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_pull, busy, sda_line;
  int   n_tests = 0, n_fail = 0, r12_viol = 0;
  longint cyc = 0;
  bit   finished = 1'b0;

  assign sda_line = sda_m & ~sda_pull;

  ee2w_slave #(.PAGE_W(2), .WRITE_CYCLES(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .dev_sel_i(SEL), .sda_pull_o(sda_pull), .busy_o(busy)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  logic prev_scl = 1'b1, prev_pull = 1'b0;
  always @(negedge clk) begin
    if (rst_n && prev_scl && scl && (sda_pull !== prev_pull)) r12_viol++;
    prev_scl  = scl;
    prev_pull = sda_pull;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  logic [7:0] exp_q[$];
  string      req_q[$];
  logic [7:0] mon_byte;
  event       mon_ev;

  task automatic expect_byte(input logic [7:0] b, input string req);
    exp_q.push_back(b);
    req_q.push_back(req);
  endtask

  initial forever begin
    @(mon_ev);
    if (exp_q.size() == 0) check("SB", 32'(mon_byte), 32'hFFFF);
    else begin
      logic [7:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      check(r, 32'(mon_byte), 32'(e));
    end
  end

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = (sda_line == 1'b0); wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit nack, input bit to_sb, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wq(); scl = 1'b1; wq(); b = {b[6:0], sda_line}; wq(); scl = 1'b0;
    end
    wq(); sda_m = nack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq(); sda_m = 1'b1;
    if (to_sb) begin
      mon_byte = b;
      ->mon_ev;
      #1;
    end
  endtask

  task automatic send_chk(input logic [7:0] b, input bit exp_ack, input string req);
    bit a;
    send_byte(b, a);
    check(req, 32'(a), 32'(exp_ack));
  endtask

  task automatic wait_idle();
    int k;
    k = 0;
    while (busy && k < 3 * WC) begin @(posedge clk); k++; end
    #1;
  endtask

  task automatic write_seq(input logic [7:0] wa, input int n, input logic [7:0] d [8], input string req);
    bus_start();
    send_chk(DEV_W, 1'b1, "R2");
    send_chk(wa, 1'b1, "R3");
    for (int k = 0; k < n; k++) send_chk(d[k], 1'b1, req);
    bus_stop();
  endtask

  task automatic read_rand(input logic [7:0] wa, input int n);
    logic [7:0] b;
    bus_start();
    send_chk(DEV_W, 1'b1, "R8");
    send_chk(wa, 1'b1, "R8");
    bus_start();
    send_chk(DEV_R, 1'b1, "R8");
    for (int k = 0; k < n; k++) recv_byte(k == n - 1, 1'b1, b);
    wq();
    check("R11", 32'(sda_pull), 32'd0);
    bus_stop();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog timeout got 0 expected 1");
      finish_run();
    end
  end

  initial begin
    logic [7:0] b;
    longint t0;
    repeat (5) @(posedge clk);
    #1;
    rst_n = 1'b1;
    wq();
    // R1: reset state
    check("R1", 32'(sda_pull), 32'd0);
    check("R1", 32'(busy), 32'd0);

    // R3 / R5 / R6: byte write, lockout, write cycle length
    write_seq(8'h10, 1, '{8'hA5, 0, 0, 0, 0, 0, 0, 0}, "R3");
    t0 = cyc;
    wq();
    check("R5", 32'(busy), 32'd1);
    bus_start();
    send_chk(DEV_W, 1'b0, "R6");
    bus_stop();
    check("R6", 32'(busy), 32'd1);
    wait_idle();
    check("R5", 32'((cyc - t0) >= WC - 2*Q && (cyc - t0) <= WC), 32'd1);

    // R8 then R9: random read of 0x0F, then current-address read of 0x10
    expect_byte(8'h00, "R8");
    read_rand(8'h0F, 1);
    expect_byte(8'hA5, "R9");
    bus_start();
    send_chk(DEV_R, 1'b1, "R9");
    recv_byte(1'b1, 1'b1, b);
    bus_stop();

    // R4: six bytes into page 0x20..0x23 starting at 0x22
    write_seq(8'h22, 6, '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 0, 0}, "R4");
    wait_idle();
    check("R4", 32'(busy), 32'd0);
    expect_byte(8'h00, "R4");
    expect_byte(8'h03, "R4");
    expect_byte(8'h04, "R4");
    expect_byte(8'h05, "R4");
    expect_byte(8'h06, "R4");
    expect_byte(8'h00, "R4");
    read_rand(8'h1F, 6);

    // R10: sequential read wraps 0xFF -> 0x00
    write_seq(8'hFF, 1, '{8'h77, 0, 0, 0, 0, 0, 0, 0}, "R3");
    wait_idle();
    write_seq(8'h00, 1, '{8'h88, 0, 0, 0, 0, 0, 0, 0}, "R3");
    wait_idle();
    expect_byte(8'h77, "R10");
    expect_byte(8'h88, "R10");
    read_rand(8'hFF, 2);

    // R7: repeated start aborts a write
    bus_start();
    send_chk(DEV_W, 1'b1, "R7");
    send_chk(8'h40, 1'b1, "R7");
    send_chk(8'h99, 1'b1, "R7");
    bus_start();
    bus_stop();
    wq();
    check("R7", 32'(busy), 32'd0);
    expect_byte(8'h00, "R7");
    read_rand(8'h40, 1);

    // R2: wrong select bits, wrong type code
    bus_start();
    send_chk({4'b1010, 3'b011, 1'b0}, 1'b0, "R2");
    send_chk(8'h10, 1'b0, "R2");
    bus_stop();
    bus_start();
    send_chk({4'b1011, SEL, 1'b1}, 1'b0, "R2");
    bus_stop();

    // R11: after master NACK, extra clocks see a released line
    bus_start();
    send_chk(DEV_W, 1'b1, "R11");
    send_chk(8'h10, 1'b1, "R11");
    bus_start();
    send_chk(DEV_R, 1'b1, "R11");
    expect_byte(8'hA5, "R11");
    recv_byte(1'b1, 1'b1, b);
    recv_byte(1'b1, 1'b0, b);
    check("R11", 32'(b), 32'hFF);
    bus_stop();

    // R12: pull never moved while SCL was high
    check("R12", 32'(r12_viol), 32'd0);
    check("SB", 32'(exp_q.size()), 32'd0);
    finished = 1'b1;
    finish_run();
  end
endmodule